// File: doc/BRIEF.md
# Current-Source Inverter Space-Vector Sequencer

This block drives the six gate signals of a three-phase current-source inverter bridge from a space-vector reference. A control loop outside the block supplies three values: the sector that holds the reference current vector, numbered 1 to 6, and the two dwell counts for the active vectors that bound that sector. The block then produces one sampling period of gating. The first bounding active vector comes first, then the second, and a null vector fills whatever time is left. Every gate state turns on exactly one upper switch and one lower switch, so the DC link current always has a path.

Switches are numbered S1..S6. The upper switches are S1, S3 and S5, on legs a, b and c. The lower switches are S4, S6 and S2, on the same legs. Active vector Ik turns on switches k and k+1, where switch 6 is followed by switch 1. Sector s lies between vectors I(s-1) and Is, and sector 1 lies between I6 and I1. The null vector for a sector shorts the leg that contains the switch shared by its two active vectors. The move from the second active vector into the null vector therefore toggles only two switches.

A free-running counter times the period, whose length is programmable in clock cycles. The sector, the dwells and the period length are taken in only at period boundaries. For a low-distortion output, the caller picks a period so that each fundamental cycle holds a whole multiple of six sampling periods.

Top module: `csi_svm_mod`

## Requirements
- R1: In every cycle, `gate` has exactly one bit set among the upper bits 0, 2 and 4 (S1, S3, S5) and exactly one among the lower bits 1, 3 and 5 (S2, S4, S6). Bit n-1 drives switch Sn.
- R2: For sector s, the first segment turns on {S(s-1), Ss} and the second turns on {Ss, S(s+1)}, with switch numbers wrapping from 6 to 1. So sector 1 gives {S6,S1} then {S1,S2}.
- R3: The null segment turns on {S1,S4} in sectors 1 and 4, {S3,S6} in sectors 3 and 6, and {S5,S2} in sectors 2 and 5.
- R4: Within a period, `seg` is 0 for `dwell_a` cycles, then 1 for `dwell_b` cycles, then 2 for the remaining cycles. A zero dwell skips its segment.
- R5: A period lasts `period_len` cycles, and a value of 0 is treated as 1. `start` is high in the first cycle of each period only.
- R6: The inputs are sampled only on the clock edge that ends the last cycle of a period. Changes at any other time do not affect the period in progress.
- R7: `dwell_a` is clamped to the period length, and `dwell_b` is clamped to the period minus the clamped `dwell_a`. The null time is therefore never negative.
- R8: A sector value of 0 or 7 makes the whole period a null segment on {S1,S4}.
- R9: During reset, `gate` is {S1,S4}, `seg` is 2 and `start` is 1. The first period after reset begins with the inputs sampled on the first clock edge after release.
- R10: A segment change inside a period toggles exactly two gate bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_len | input | CNT_W | Sampling period length in cycles |
| sector | input | 3 | Sector of the reference vector, 1..6 |
| dwell_a | input | CNT_W | Cycles on the first active vector |
| dwell_b | input | CNT_W | Cycles on the second active vector |
| gate | output | 6 | Switch gates, bit n-1 = Sn |
| seg | output | 2 | Current segment: 0 first, 1 second, 2 null |
| start | output | 1 | High in the first cycle of a period |

## Verification
Four properties are checked on every cycle:
- the one-upper/one-lower gate invariant;
- that any null state is one of the three shorted legs;
- that segments never step backward within a period and the gates hold steady inside a segment;
- that every segment boundary toggles exactly two switches.

The per-sector vector choice, the exact segment lengths, the clamping of oversized dwells, the treatment of invalid sectors and zero-length periods, and the rule that inputs are sampled only at the period boundary depend on the input values. Only the bench's scoreboard shows these, by comparing every cycle against a sequence computed from the requirements.

// File: rtl/csi_svm_pkg.sv
package csi_svm_pkg;

    typedef enum logic [1:0] {
        SEG_FIRST  = 2'd0,
        SEG_SECOND = 2'd1,
        SEG_NULL   = 2'd2
    } seg_e;

    localparam int NUM_SW = 6;

    // map any integer onto switch number 1..6
    function automatic int wrap_sw(int n);
        int m;
        m = n - 1;
        m = ((m % NUM_SW) + NUM_SW) % NUM_SW;
        return m + 1;
    endfunction

    function automatic logic [5:0] sw_mask(int n);
        logic [5:0] r;
        r = '0;
        r[wrap_sw(n) - 1] = 1'b1;
        return r;
    endfunction

    // active vector k conducts through switches k and k+1
    function automatic logic [5:0] active_vec(int k);
        return sw_mask(k) | sw_mask(k + 1);
    endfunction

    // null vector shorting the leg of switch s (s and s+3 share a leg)
    function automatic logic [5:0] leg_short(int s);
        return sw_mask(s) | sw_mask(s + 3);
    endfunction

endpackage

// File: rtl/csi_svm_sat.sv
module csi_svm_sat #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] plen_i,
    input  logic [CNT_W-1:0] a_i,
    input  logic [CNT_W-1:0] b_i,
    input  logic             valid_i,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] ta_o,
    output logic [CNT_W-1:0] tb_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] per_c;
    logic [CNT_W-1:0] ta_c;
    logic [CNT_W-1:0] rem_c;
    logic [CNT_W-1:0] tb_c;

    always_comb begin
        per_c = (plen_i == '0) ? ONE : plen_i;
        ta_c  = (a_i > per_c) ? per_c : a_i;
        rem_c = per_c - ta_c;
        tb_c  = (b_i > rem_c) ? rem_c : b_i;
        per_o = per_c;
        ta_o  = valid_i ? ta_c : '0;
        tb_o  = valid_i ? tb_c : '0;
    end
endmodule

// File: rtl/csi_svm_segdec.sv
module csi_svm_segdec
    import csi_svm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] ta_i,
    input  logic [CNT_W-1:0] tb_i,
    output seg_e             seg_o
);
    logic [CNT_W:0] edge_b;

    always_comb begin
        edge_b = {1'b0, ta_i} + {1'b0, tb_i};
        if (cnt_i < ta_i)
            seg_o = SEG_FIRST;
        else if ({1'b0, cnt_i} < edge_b)
            seg_o = SEG_SECOND;
        else
            seg_o = SEG_NULL;
    end
endmodule

// File: rtl/csi_svm_vecsel.sv
module csi_svm_vecsel
    import csi_svm_pkg::*;
(
    input  logic [2:0] sec_i,
    output logic [5:0] first_o,
    output logic [5:0] second_o,
    output logic [5:0] null_o
);
    logic [5:0] lut_first  [8];
    logic [5:0] lut_second [8];
    logic [5:0] lut_null   [8];

    for (genvar g = 0; g < 8; g++) begin : g_sec
        if (g >= 1 && g <= 6) begin : g_ok
            assign lut_first[g]  = active_vec(g - 1);
            assign lut_second[g] = active_vec(g);
            // shared switch of the pair is switch g; short its leg
            assign lut_null[g]   = leg_short(g);
        end else begin : g_bad
            assign lut_first[g]  = leg_short(1);
            assign lut_second[g] = leg_short(1);
            assign lut_null[g]   = leg_short(1);
        end
    end

    assign first_o  = lut_first[sec_i];
    assign second_o = lut_second[sec_i];
    assign null_o   = lut_null[sec_i];
endmodule

// File: rtl/csi_svm_mod.sv
module csi_svm_mod
    import csi_svm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_len,
    input  logic [2:0]       sector,
    input  logic [CNT_W-1:0] dwell_a,
    input  logic [CNT_W-1:0] dwell_b,
    output logic [5:0]       gate,
    output logic [1:0]       seg,
    output logic             start
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] ta;
        logic [CNT_W-1:0] tb;
        logic [2:0]       sec;
    } core_t;

    typedef struct packed {
        seg_e       seg;
        logic [5:0] gate;
        logic       start;
    } out_t;

    core_t core_d, core_q;
    out_t  out_d,  out_q;

    logic             wrap;
    logic             in_valid;
    logic [CNT_W-1:0] sat_per, sat_ta, sat_tb;
    seg_e             seg_nx;
    logic [5:0]       v_first, v_second, v_null;

    assign in_valid = (sector != 3'd0) && (sector != 3'd7);

    csi_svm_sat #(.CNT_W(CNT_W)) u_sat (
        .plen_i (period_len),
        .a_i    (dwell_a),
        .b_i    (dwell_b),
        .valid_i(in_valid),
        .per_o  (sat_per),
        .ta_o   (sat_ta),
        .tb_o   (sat_tb)
    );

    // period timing and boundary sampling
    always_comb begin
        wrap   = (core_q.cnt == (core_q.per - ONE));
        core_d = core_q;
        if (wrap) begin
            core_d.cnt = '0;
            core_d.per = sat_per;
            core_d.ta  = sat_ta;
            core_d.tb  = sat_tb;
            core_d.sec = in_valid ? sector : 3'd0;
        end else begin
            core_d.cnt = core_q.cnt + ONE;
        end
    end

    csi_svm_segdec #(.CNT_W(CNT_W)) u_segdec (
        .cnt_i(core_d.cnt),
        .ta_i (core_d.ta),
        .tb_i (core_d.tb),
        .seg_o(seg_nx)
    );

    csi_svm_vecsel u_vecsel (
        .sec_i   (core_d.sec),
        .first_o (v_first),
        .second_o(v_second),
        .null_o  (v_null)
    );

    // registered gate outputs, aligned with the counter
    always_comb begin
        out_d.seg   = seg_nx;
        out_d.start = (core_d.cnt == '0);
        case (seg_nx)
            SEG_FIRST:  out_d.gate = v_first;
            SEG_SECOND: out_d.gate = v_second;
            default:    out_d.gate = v_null;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.cnt  <= '0;
            core_q.per  <= ONE;
            core_q.ta   <= '0;
            core_q.tb   <= '0;
            core_q.sec  <= 3'd1;
            out_q.seg   <= SEG_NULL;
            out_q.gate  <= leg_short(1);
            out_q.start <= 1'b1;
        end else begin
            core_q <= core_d;
            out_q  <= out_d;
        end
    end

    assign gate  = out_q.gate;
    assign seg   = out_q.seg;
    assign start = out_q.start;
endmodule

// File: rtl/csi_svm_chk.sv
module csi_svm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] gate,
    input logic [1:0] seg,
    input logic       start
);
    localparam logic [5:0] UPPER = 6'b010101;
    localparam logic [5:0] LOWER = 6'b101010;

    // R1
    one_up_one_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gate & UPPER) == 1) && ($countones(gate & LOWER) == 1));

    // R3
    null_is_leg_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == 2'd2) |-> (gate == 6'b001001 || gate == 6'b100100 || gate == 6'b010010));

    // R4
    seg_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> (seg >= $past(seg)));

    // R4
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && seg == $past(seg)) |-> $stable(gate));

    // R10
    two_switch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && seg != $past(seg)) |-> ($countones(gate ^ $past(gate)) == 2));
endmodule

bind csi_svm_mod csi_svm_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .gate (gate),
    .seg  (seg),
    .start(start)
);

// File: tb/csi_svm_mod_test.sv
module csi_svm_mod_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] period_len = '0;
    logic [W-1:0] dwell_a = '0;
    logic [W-1:0] dwell_b = '0;
    logic [2:0]   sector = 3'd1;
    logic [5:0]   gate;
    logic [1:0]   seg;
    logic         start;

    always #(CLK_PERIOD/2) clk = ~clk;

    csi_svm_mod #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .period_len(period_len), .sector(sector),
        .dwell_a(dwell_a), .dwell_b(dwell_b), .gate(gate), .seg(seg), .start(start)
    );

    typedef struct {
        logic [5:0] gate;
        logic [1:0] seg;
        logic       start;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    // active vectors: I1 {S1,S2} .. I6 {S6,S1}; bit n-1 = Sn
    function automatic logic [5:0] act(int k);
        case (k)
            1: return 6'b000011;
            2: return 6'b000110;
            3: return 6'b001100;
            4: return 6'b011000;
            5: return 6'b110000;
            default: return 6'b100001;
        endcase
    endfunction

    // R3 null per sector
    function automatic logic [5:0] nul(int s);
        case (s)
            1, 4: return 6'b001001;
            3, 6: return 6'b100100;
            2, 5: return 6'b010010;
            default: return 6'b001001;
        endcase
    endfunction

    task automatic push_period(int p, int s, int a, int b, string tag);
        int per, ta, tb;
        bit ok;
        exp_t e;
        period_len = p[W-1:0];
        sector     = s[2:0];
        dwell_a    = a[W-1:0];
        dwell_b    = b[W-1:0];
        per = (p == 0) ? 1 : p;                  // R5
        ok  = (s >= 1 && s <= 6);                // R8
        ta  = ok ? ((a > per) ? per : a) : 0;    // R7
        tb  = ok ? ((b > per - ta) ? per - ta : b) : 0;
        for (int c = 0; c < per; c++) begin
            e.start = (c == 0);
            e.tag   = tag;
            if (c < ta) begin
                e.seg  = 2'd0;
                e.gate = act((s == 1) ? 6 : s - 1);   // R2
            end else if (c < ta + tb) begin
                e.seg  = 2'd1;
                e.gate = act(s);                      // R2
            end else begin
                e.seg  = 2'd2;
                e.gate = ok ? nul(s) : 6'b001001;     // R3 / R8
            end
            q.push_back(e);
        end
    endtask

    // R6: inputs for the next period are written while the current one runs
    task automatic next_period(int p, int s, int a, int b, string tag);
        do @(negedge clk); while (start !== 1'b1);
        #1;
        push_period(p, s, a, b, tag);
    endtask

    task automatic report(bit ok, string tag, string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // monitor / scoreboard
    logic [5:0] prev_gate;
    logic [1:0] prev_seg;
    bit         have_prev = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                // R1 every cycle
                report(($countones(gate & 6'b010101) == 1) && ($countones(gate & 6'b101010) == 1),
                       "R1", $sformatf("gate=%b expected one upper and one lower bit", gate));
                // R10
                if (have_prev && start !== 1'b1 && seg !== prev_seg)
                    report($countones(gate ^ prev_gate) == 2, "R10",
                           $sformatf("toggled=%0d expected=2", $countones(gate ^ prev_gate)));
                if (q.size() > 0 && !(q[0].start && start !== 1'b1)) begin
                    exp_t h;
                    h = q.pop_front();
                    report(gate === h.gate && seg === h.seg && start === h.start, h.tag,
                           $sformatf("gate=%b seg=%0d start=%b expected gate=%b seg=%0d start=%b",
                                     gate, seg, start, h.gate, h.seg, h.start));
                end
                prev_gate = gate;
                prev_seg  = seg;
                have_prev = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        report(gate === 6'b001001 && seg === 2'd2 && start === 1'b1, "R9",
               $sformatf("gate=%b seg=%0d start=%b expected gate=001001 seg=2 start=1", gate, seg, start));
        push_period(20, 2, 5, 7, "R9 R2 R3 R4 first period sector 2");
        @(negedge clk);
        #1 rst_n = 1'b1;

        next_period(12, 1, 3, 4, "R2 R3 sector 1");
        next_period(12, 3, 2, 6, "R2 R3 sector 3");
        next_period(12, 4, 4, 4, "R2 R3 sector 4");
        next_period(12, 5, 6, 1, "R2 R3 sector 5");
        next_period(12, 6, 1, 1, "R2 R3 sector 6");
        next_period(16, 2, 0, 9, "R4 first dwell zero");
        next_period(16, 5, 7, 0, "R4 second dwell zero");
        next_period(10, 3, 4, 6, "R7 dwells fill period");
        next_period(20, 4, 15, 10, "R7 dwell sum over period");
        next_period(20, 6, 30, 4, "R7 first dwell over period");
        next_period(9, 0, 3, 3, "R8 sector 0");
        next_period(9, 7, 2, 2, "R8 sector 7");
        next_period(0, 2, 1, 1, "R5 zero length period");
        next_period(1, 4, 0, 0, "R5 one cycle null period");
        next_period(3, 1, 1, 1, "R5 short period");
        next_period(24, 1, 8, 8, "R6 final period");

        for (int i = 0; i < 2000 && q.size() > 0; i++) @(negedge clk);
        report(q.size() == 0, "R6", $sformatf("left=%0d expected=0", q.size()));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule